// File: doc/BRIEF.md
# Programmable Serial Master for an External ADC

This block drives a serial analog-to-digital converter from one 32-bit command word. A single host write both holds the bits sent to the converter and starts a frame. The block then makes a shift clock from the system clock, raises a frame marker for the first bit period and sends the command most significant bit first. It also shifts the converter's data line into a 16-bit capture register, on the rising or the falling shift-clock edge. A busy flag covers the whole frame. At the end of the frame a completion interrupt is raised, and it stays up until the host reads the capture register. A separate clock output can run freely at twice the shift rate, whether or not a frame is in progress.

The command has two layouts, chosen by the `ext_mode` input. The short layout sends a fixed 8-bit command. The long layout sends a command of 8 to 16 bits, taken from the upper half-word, with its length given in a low field. In both layouts the frame length sets how many shift periods the frame lasts: command bits, then idle zeros, then result bits.

The sequencer is a four-state machine. IDLE waits for a write with the start bit set (IDLE→ARM). ARM waits for the next divider tick, so the first bit period has full width (ARM→RUN). RUN steps through four ticks per bit and leaves after the last bit period (RUN→DONE). DONE lasts one cycle, raises the interrupt and returns (DONE→IDLE).

Top module: `adcser_master`

## Requirements
- R1: After reset the machine is in IDLE. `busy`, `eot_irq`, `adc_sclk`, `adc_fsync`, `adc_mosi` and `smp_clk` are low and `rd_data` is zero.
- R2: Short layout (`ext_mode`=0): the command is `wr_data[7:0]`. It goes out on `adc_mosi` from bit 7 down to bit 0, one bit per shift period. Each bit is held for the whole period.
- R3: Long layout (`ext_mode`=1): the command length is `wr_data[6:0]`, forced up to 8 when smaller and down to 16 when larger. For a length L, bits `wr_data[16+L-1]` down to `wr_data[16]` are sent, highest first.
- R4: The frame length F is taken from `wr_data[12:8]` in the short layout and from `wr_data[12:7]` in the long layout. A value of 0 counts as 1. The frame has exactly F shift periods. After the command bits, `adc_mosi` is 0.
- R5: Bit 14 of a write is the start bit and bit 13 is the sample-clock enable. A write with bit 14 clear starts no frame, but it still loads bit 13 into the sample-clock enable.
- R6: A divider tick occurs every `div_sel`+1 system clocks. The first shift period begins at the first tick after the start write. Each period lasts four ticks: `adc_sclk` is low for two ticks, then high for two.
- R7: `adc_fsync` is high for exactly the first shift period of a frame, which is 4×(`div_sel`+1) clocks.
- R8: With `edge_fall`=0, `adc_miso` is shifted into bit 0 of the capture register on the edge where `adc_sclk` rises. With `edge_fall`=1 it is shifted in where `adc_sclk` falls. `rd_data` shows the last 16 bits captured.
- R9: `busy` rises in the cycle after the start write is accepted and stays high until the frame has ended.
- R10: `eot_irq` rises as `busy` falls and stays high until a cycle with `rd_en` high. If it is being raised in that same cycle, raising wins.
- R11: When enabled, `smp_clk` toggles on every divider tick, so it runs at twice the `adc_sclk` frequency. When disabled it is held low. Frames do not affect it.
- R12: A write with bit 14 set that arrives while `busy` is high is dropped as a whole: the running frame and the sample-clock enable are left unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Host write strobe for the command word |
| wr_data | input | 32 | Command word |
| rd_en | input | 1 | Host read strobe; clears the interrupt |
| rd_data | output | 16 | Last 16 captured converter bits |
| ext_mode | input | 1 | 0: short 8-bit command, 1: long variable command |
| edge_fall | input | 1 | 0: sample on rising shift edge, 1: on falling edge |
| div_sel | input | DIV_W | Divider tick spacing minus one, in system clocks |
| adc_sclk | output | 1 | Shift clock to the converter |
| adc_fsync | output | 1 | Frame marker during the first bit period |
| adc_mosi | output | 1 | Serial command data to the converter |
| adc_miso | input | 1 | Serial result data from the converter |
| smp_clk | output | 1 | Free-running sample clock, twice the shift rate |
| busy | output | 1 | Frame in progress |
| eot_irq | output | 1 | Frame-complete interrupt |

## Verification
The command path is tried in both layouts: a normal 10-bit long command, a length field below 8 and one above 16 (which show the clamp), and a frame of zero length (which shows the minimum of one period). The converter model changes `adc_miso` after every rising shift edge. A frame captured on the rising edge therefore differs by one bit position from one captured on the falling edge, so a wrong edge choice shows in `rd_data`. Writes placed in the middle of a frame are checked both with the start bit set, which must change nothing, and with it clear, which must switch the sample clock on. Two divider settings show that periods scale with `div_sel`.

// File: rtl/adcser_pkg.sv
`timescale 1ns/1ps
package adcser_pkg;
    localparam int WORD_W    = 32;
    localparam int CAP_W     = 16;
    localparam int CMD_MAX   = 16;
    localparam int CMD_MIN   = 8;
    localparam int CLEN_W    = $clog2(CMD_MAX + 1);
    localparam int FLEN_W    = 6;
    localparam int START_BIT = 14;
    localparam int SMCK_BIT  = 13;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ARM  = 2'd1,
        ST_RUN  = 2'd2,
        ST_DONE = 2'd3
    } seq_state_e;

    typedef struct packed {
        logic [CMD_MAX-1:0] cmd;
        logic [CLEN_W-1:0]  cmd_len;
        logic [FLEN_W-1:0]  frame_len;
    } xfer_cfg_t;
endpackage

// File: rtl/adcser_prescale.sv
`timescale 1ns/1ps
module adcser_prescale #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] div_sel,
    input  logic             smck_en,
    output logic             tick,
    output logic             smp_clk
);
    logic [DIV_W-1:0] cnt_q;
    logic             smp_q;

    assign tick    = (cnt_q >= div_sel);
    assign smp_clk = smp_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (tick) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            smp_q <= 1'b0;
        end else if (!smck_en) begin
            smp_q <= 1'b0;
        end else if (tick) begin
            smp_q <= ~smp_q;
        end
    end

    AST_SMP_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(smp_q) |-> ($past(tick) || !smp_q)); // R11
endmodule

// File: rtl/adcser_word_decode.sv
`timescale 1ns/1ps
module adcser_word_decode
    import adcser_pkg::*;
(
    input  logic [WORD_W-1:0] word,
    input  logic              ext_mode,
    output xfer_cfg_t         cfg
);
    logic [6:0]        len_raw;
    logic [CLEN_W-1:0] len_ext;
    logic              unused_ctl;

    assign unused_ctl = ^word[15:13];
    assign len_raw    = word[6:0];

    always_comb begin
        if (len_raw < 7'(CMD_MIN)) begin
            len_ext = CLEN_W'(CMD_MIN);
        end else if (len_raw > 7'(CMD_MAX)) begin
            len_ext = CLEN_W'(CMD_MAX);
        end else begin
            len_ext = len_raw[CLEN_W-1:0];
        end
    end

    always_comb begin
        if (ext_mode) begin
            cfg.cmd       = word[WORD_W-1:16] << (CMD_MAX - int'(len_ext));
            cfg.cmd_len   = len_ext;
            cfg.frame_len = word[12:7];
        end else begin
            cfg.cmd       = {word[7:0], 8'h00};
            cfg.cmd_len   = CLEN_W'(CMD_MIN);
            cfg.frame_len = {1'b0, word[12:8]};
        end
    end
endmodule

// File: rtl/adcser_seq.sv
`timescale 1ns/1ps
module adcser_seq
    import adcser_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             start,
    input  xfer_cfg_t        cfg_in,
    input  logic             edge_sel,
    input  logic             rd_en,
    input  logic             miso,
    output logic             sclk,
    output logic             fsync,
    output logic             mosi,
    output logic             busy,
    output logic             eot_irq,
    output logic [CAP_W-1:0] cap_data
);
    seq_state_e         st_q, st_d;
    logic [1:0]         ph_q;
    logic [FLEN_W-1:0]  bit_q;
    logic [FLEN_W-1:0]  last_q;
    logic [CLEN_W-1:0]  clen_q;
    logic [CMD_MAX-1:0] sh_q;
    logic               edge_q;
    logic [CAP_W-1:0]   cap_q;
    logic               irq_q;
    logic               period_end;
    logic               sample_now;

    assign period_end = tick && (ph_q == 2'd3);
    assign sample_now = (st_q == ST_RUN) && tick &&
                        ((!edge_q && ph_q == 2'd1) || (edge_q && ph_q == 2'd3));

    // next-state logic
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE: if (start) st_d = ST_ARM;
            ST_ARM:  if (tick) st_d = ST_RUN;
            ST_RUN:  if (period_end && bit_q == last_q) st_d = ST_DONE;
            ST_DONE: st_d = ST_IDLE;
            default: st_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    // frame datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ph_q   <= '0;
            bit_q  <= '0;
            last_q <= '0;
            clen_q <= '0;
            sh_q   <= '0;
            edge_q <= 1'b0;
        end else begin
            if (st_q == ST_IDLE && start) begin
                sh_q   <= cfg_in.cmd;
                clen_q <= cfg_in.cmd_len;
                last_q <= (cfg_in.frame_len == '0) ? '0 : cfg_in.frame_len - 1'b1;
                edge_q <= edge_sel;
            end
            if (st_q == ST_ARM && tick) begin
                ph_q  <= '0;
                bit_q <= '0;
            end
            if (st_q == ST_RUN && tick) begin
                ph_q <= ph_q + 1'b1;
                if (ph_q == 2'd3) begin
                    sh_q <= sh_q << 1;
                    if (bit_q != last_q) bit_q <= bit_q + 1'b1;
                end
            end
        end
    end

    // capture register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          cap_q <= '0;
        else if (sample_now) cap_q <= {cap_q[CAP_W-2:0], miso};
    end

    // completion interrupt
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                irq_q <= 1'b0;
        else if (st_q == ST_DONE)  irq_q <= 1'b1;
        else if (rd_en)            irq_q <= 1'b0;
    end

    // outputs
    always_comb begin
        busy     = (st_q != ST_IDLE);
        sclk     = (st_q == ST_RUN) && ph_q[1];
        fsync    = (st_q == ST_RUN) && (bit_q == '0);
        mosi     = (st_q == ST_RUN) && (bit_q < FLEN_W'(clen_q)) && sh_q[CMD_MAX-1];
        eot_irq  = irq_q;
        cap_data = cap_q;
    end

    AST_IRQ_ON_END: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> eot_irq); // R10
    AST_FSYNC_AFTER_ARM: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fsync) |-> $past(st_q == ST_ARM)); // R7
    AST_BUSY_START_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q != ST_IDLE && start) |=> ($stable(clen_q) && $stable(last_q) && $stable(edge_q))); // R12
    AST_CAP_ON_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cap_q) |-> ($past(st_q == ST_RUN) && $past(tick))); // R8
endmodule

// File: rtl/adcser_master.sv
`timescale 1ns/1ps
module adcser_master
    import adcser_pkg::*;
#(
    parameter int DIV_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [WORD_W-1:0] wr_data,
    input  logic              rd_en,
    output logic [CAP_W-1:0]  rd_data,
    input  logic              ext_mode,
    input  logic              edge_fall,
    input  logic [DIV_W-1:0]  div_sel,
    output logic              adc_sclk,
    output logic              adc_fsync,
    output logic              adc_mosi,
    input  logic              adc_miso,
    output logic              smp_clk,
    output logic              busy,
    output logic              eot_irq
);
    logic      tick;
    logic      smck_q;
    logic      start_req;
    logic      accept_wr;
    xfer_cfg_t cfg;
    logic      unused_bit15;

    assign unused_bit15 = wr_data[15];
    assign start_req    = wr_en && wr_data[START_BIT];
    assign accept_wr    = wr_en && !(busy && wr_data[START_BIT]);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         smck_q <= 1'b0;
        else if (accept_wr) smck_q <= wr_data[SMCK_BIT];
    end

    adcser_prescale #(.DIV_W(DIV_W)) u_pre (
        .clk     (clk),
        .rst_n   (rst_n),
        .div_sel (div_sel),
        .smck_en (smck_q),
        .tick    (tick),
        .smp_clk (smp_clk)
    );

    adcser_word_decode u_dec (
        .word     (wr_data),
        .ext_mode (ext_mode),
        .cfg      (cfg)
    );

    adcser_seq u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .start    (start_req),
        .cfg_in   (cfg),
        .edge_sel (edge_fall),
        .rd_en    (rd_en),
        .miso     (adc_miso),
        .sclk     (adc_sclk),
        .fsync    (adc_fsync),
        .mosi     (adc_mosi),
        .busy     (busy),
        .eot_irq  (eot_irq),
        .cap_data (rd_data)
    );

    AST_LINE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!adc_sclk && !adc_mosi && !adc_fsync)); // R9
    AST_SMCK_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && wr_en && wr_data[START_BIT]) |=> $stable(smck_q)); // R12
endmodule

// File: tb/tb_adcser_master.sv
`timescale 1ns/1ps
module tb_adcser_master;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic        rd_en = 1'b0;
    logic [15:0] rd_data;
    logic        ext_mode = 1'b0;
    logic        edge_fall = 1'b0;
    logic [7:0]  div_sel = 8'd1;
    logic        adc_sclk, adc_fsync, adc_mosi, smp_clk, busy, eot_irq;
    logic        adc_miso = 1'b0;

    always #2.5 clk = ~clk;

    adcser_master #(.DIV_W(8)) dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en),
        .rd_data(rd_data), .ext_mode(ext_mode), .edge_fall(edge_fall), .div_sel(div_sel),
        .adc_sclk(adc_sclk), .adc_fsync(adc_fsync), .adc_mosi(adc_mosi), .adc_miso(adc_miso),
        .smp_clk(smp_clk), .busy(busy), .eot_irq(eot_irq)
    );

    int checks = 0;
    int errors = 0;
    logic [31:0] pat_word = 32'hB5C3_9A1E;

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    function automatic int pbit(input int k);
        return int'(pat_word[k % 32]);
    endfunction

    function automatic void decode(input logic [31:0] w, input bit ext,
                                   output int clen, output int cmd, output int flen);
        int raw;
        if (ext) begin
            raw  = int'(w[6:0]);
            clen = (raw < 8) ? 8 : ((raw > 16) ? 16 : raw);
            cmd  = int'(w[31:16]) & ((1 << clen) - 1);
            flen = int'(w[12:7]);
        end else begin
            clen = 8;
            cmd  = int'(w[7:0]);
            flen = int'(w[12:8]);
        end
        if (flen == 0) flen = 1;
    endfunction

    // behavioural reference model
    int m_pre, m_st, m_q, m_bit, m_flen, m_clen, m_cmd, m_cap;
    bit m_smp, m_smck, m_irq, m_edge, m_tk, n_irq, n_smp;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_pre = 0; m_st = 0; m_q = 0; m_bit = 0; m_flen = 1; m_clen = 8; m_cmd = 0;
            m_cap = 0; m_smp = 0; m_smck = 0; m_irq = 0; m_edge = 0;
        end else begin
            m_tk  = (m_pre >= int'(div_sel));
            n_irq = (m_st == 3) ? 1'b1 : (rd_en ? 1'b0 : m_irq);
            n_smp = m_smck ? (m_tk ? !m_smp : m_smp) : 1'b0;
            if (wr_en && !(m_st != 0 && wr_data[14])) m_smck = wr_data[13];
            case (m_st)
                0: if (wr_en && wr_data[14]) begin
                       decode(wr_data, ext_mode, m_clen, m_cmd, m_flen);
                       m_edge = edge_fall;
                       m_st = 1;
                   end
                1: if (m_tk) begin m_st = 2; m_q = 0; m_bit = 0; end
                2: if (m_tk) begin
                       if ((!m_edge && m_q == 1) || (m_edge && m_q == 3))
                           m_cap = ((m_cap << 1) | int'(adc_miso)) & 32'hFFFF;
                       if (m_q == 3) begin
                           m_q = 0;
                           if (m_bit == m_flen - 1) m_st = 3;
                           else m_bit++;
                       end else m_q++;
                   end
                default: m_st = 0;
            endcase
            m_irq = n_irq;
            m_smp = n_smp;
            m_pre = m_tk ? 0 : m_pre + 1;
        end
    end

    // comparison, bus monitor and converter model
    bit seen[$];
    int fs_cnt, hi_cnt, smp_tgl, adc_idx;
    bit prev_sclk, prev_smp;
    int e_mosi;

    always @(negedge clk) begin
        if (rst_n) begin
            e_mosi = (m_st == 2 && m_bit < m_clen) ? ((m_cmd >> (m_clen - 1 - m_bit)) & 1) : 0;
            chk(adc_sclk === (m_st == 2 && m_q >= 2), "R6", "model sclk", int'(adc_sclk), int'(m_st == 2 && m_q >= 2));
            chk(adc_fsync === (m_st == 2 && m_bit == 0), "R7", "model fsync", int'(adc_fsync), int'(m_st == 2 && m_bit == 0));
            chk(int'(adc_mosi) == e_mosi, "R2", "model mosi", int'(adc_mosi), e_mosi);
            chk(busy === (m_st != 0), "R9", "model busy", int'(busy), int'(m_st != 0));
            chk(eot_irq === m_irq, "R10", "model irq", int'(eot_irq), int'(m_irq));
            chk(smp_clk === m_smp, "R11", "model smp_clk", int'(smp_clk), int'(m_smp));
            chk(int'(rd_data) == m_cap, "R8", "model rd_data", int'(rd_data), m_cap);
            if (adc_sclk && !prev_sclk) seen.push_back(adc_mosi);
            if (adc_fsync) fs_cnt++;
            if (adc_sclk) hi_cnt++;
            if (smp_clk != prev_smp) smp_tgl++;
            if (!busy) adc_idx = 0;
            else if (adc_sclk && !prev_sclk) adc_idx++;
            adc_miso = pbit(adc_idx)[0];
        end
        prev_sclk = adc_sclk;
        prev_smp  = smp_clk;
    end

    int cyc = 0;
    always @(posedge clk) begin
        cyc++;
        if (cyc >= 150000) begin
            checks++; errors++;
            $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
            summary();
            $finish;
        end
    end

    task automatic wait_idle();
        int n = 0;
        while (busy && n < 20000) begin @(negedge clk); n++; end
    endtask

    task automatic run_xfer(input logic [31:0] w, input bit ext, input bit fall,
                            input int dv, input string rq);
        int clen, cmd, flen, expv, e;
        decode(w, ext, clen, cmd, flen);
        @(negedge clk);
        ext_mode = ext; edge_fall = fall; div_sel = 8'(dv);
        seen.delete(); fs_cnt = 0; hi_cnt = 0;
        wr_en = 1'b1; wr_data = w;
        @(negedge clk);
        wr_en = 1'b0;
        chk(busy === 1'b1, "R9", "busy after start", int'(busy), 1);
        wait_idle();
        chk(seen.size() == flen, "R4", "period count", seen.size(), flen);
        for (int i = 0; i < seen.size(); i++) begin
            e = (i < clen) ? ((cmd >> (clen - 1 - i)) & 1) : 0;
            chk(int'(seen[i]) == e, (i < clen) ? rq : "R4", "serial bit", int'(seen[i]), e);
        end
        chk(fs_cnt == 4 * (dv + 1), "R7", "fsync width", fs_cnt, 4 * (dv + 1));
        chk(hi_cnt == flen * 2 * (dv + 1), "R6", "sclk high cycles", hi_cnt, flen * 2 * (dv + 1));
        chk(eot_irq === 1'b1, "R10", "irq at end", int'(eot_irq), 1);
        if (flen >= 16) begin
            expv = 0;
            for (int k = (fall ? flen - 15 : flen - 16); k <= (fall ? flen : flen - 1); k++)
                expv = ((expv << 1) | pbit(k)) & 32'hFFFF;
            chk(int'(rd_data) == expv, "R8", fall ? "falling capture" : "rising capture", int'(rd_data), expv);
        end
        @(negedge clk); rd_en = 1'b1;
        @(negedge clk); rd_en = 1'b0;
        chk(eot_irq === 1'b0, "R10", "irq cleared by read", int'(eot_irq), 0);
    endtask

    task automatic host_write(input logic [31:0] w);
        @(negedge clk); wr_en = 1'b1; wr_data = w;
        @(negedge clk); wr_en = 1'b0;
    endtask

    initial begin
        int clen, cmd, flen, e;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(busy === 1'b0 && eot_irq === 1'b0, "R1", "busy/irq after reset", int'({busy, eot_irq}), 0);
        chk({adc_sclk, adc_fsync, adc_mosi, smp_clk} === 4'b0, "R1", "lines after reset",
            int'({adc_sclk, adc_fsync, adc_mosi, smp_clk}), 0);
        chk(rd_data === 16'h0, "R1", "rd_data after reset", int'(rd_data), 0);

        // short layout, frame 25, rising edge
        run_xfer(32'h0000_4000 | (25 << 8) | 32'hA5, 1'b0, 1'b0, 1, "R2");
        // short layout, frame 20, falling edge, fastest divider
        run_xfer(32'h0000_4000 | (20 << 8) | 32'h3C, 1'b0, 1'b1, 0, "R2");
        // long layout, 10-bit command, frame 23
        run_xfer(32'h0000_4000 | (32'h2D5 << 16) | (23 << 7) | 10, 1'b1, 1'b0, 1, "R3");
        // long layout, length field below minimum
        run_xfer(32'h0000_4000 | (32'hF0F1 << 16) | (18 << 7) | 3, 1'b1, 1'b1, 0, "R3");
        // long layout, length field above maximum, frame 40
        run_xfer(32'h0000_4000 | (32'hC3A5 << 16) | (40 << 7) | 30, 1'b1, 1'b0, 0, "R3");
        // zero frame length counts as one period
        run_xfer(32'h0000_4000 | 32'h81, 1'b0, 1'b0, 1, "R4");

        // R5 write without start bit
        host_write(32'h0000_1FFF & ~32'h2000);
        chk(busy === 1'b0, "R5", "no frame without start bit", int'(busy), 0);
        repeat (10) @(negedge clk);
        chk(busy === 1'b0 && seen.size() == 1, "R5", "still idle", int'(busy), 0);

        // R11 sample clock rate and disable
        div_sel = 8'd1;
        host_write(32'h0000_2000);
        repeat (4) @(negedge clk);
        smp_tgl = 0;
        repeat (40) @(negedge clk);
        chk(smp_tgl == 20, "R11", "sample clock toggles in 40 clocks", smp_tgl, 20);
        host_write(32'h0000_0000);
        repeat (2) @(negedge clk);
        smp_tgl = 0;
        repeat (12) @(negedge clk);
        chk(smp_tgl == 0 && smp_clk === 1'b0, "R11", "sample clock held low", smp_tgl, 0);

        // R12 start write during a frame is dropped
        decode(32'h0000_4000 | (18 << 8) | 32'h96, 1'b0, clen, cmd, flen);
        ext_mode = 1'b0; edge_fall = 1'b0;
        seen.delete();
        host_write(32'h0000_4000 | (18 << 8) | 32'h96);
        repeat (20) @(negedge clk);
        smp_tgl = 0;
        host_write(32'h0000_6000 | (9 << 8) | 32'h0F);
        wait_idle();
        chk(seen.size() == flen, "R12", "frame length kept", seen.size(), flen);
        for (int i = 0; i < clen; i++) begin
            e = (cmd >> (clen - 1 - i)) & 1;
            chk(int'(seen[i]) == e, "R12", "command kept", int'(seen[i]), e);
        end
        chk(smp_tgl == 0, "R12", "sample enable kept", smp_tgl, 0);
        @(negedge clk); rd_en = 1'b1; @(negedge clk); rd_en = 1'b0;

        // R5 non-start write during a frame still sets the sample enable
        host_write(32'h0000_4000 | (18 << 8) | 32'h5A);
        repeat (10) @(negedge clk);
        host_write(32'h0000_2000);
        smp_tgl = 0;
        repeat (20) @(negedge clk);
        chk(smp_tgl > 0, "R5", "sample enable set while busy", smp_tgl, 10);
        wait_idle();
        host_write(32'h0000_0000);
        repeat (8) @(negedge clk);

        summary();
        $finish;
    end
endmodule